// File: doc/BRIEF.md
# Two-Stage SD Card Clock Enable Generator

This block derives the clock enables for an SD/eMMC host controller from a single parent clock. A first stage divides the parent by a power of two to form the high-speed host clock. A second stage divides that result by two or four to form the card clock. Each output has its own stop bit. Both outputs are single-cycle enables in the parent domain. A downstream gating cell or register enable uses them, so no derived clock net is ever created.

Software programs one control word that holds the first-stage code, the second-stage select and the two stop bits, and can read the word back at once. A written setting does not reach the dividers straight away. It is held until the current card-clock period ends, so the outputs never produce a shortened period while a change is in progress. At reset both outputs are stopped, and the divide fields hold the setting of a ÷4 card clock.

Top module: `sdclk_gen`

## Requirements
- R1: Read-back returns the last written value of bits [9:8] and [4:0] starting the cycle after the write; every other bit reads 0.
- R2: After reset, read-back is 0x0301 (both stop bits set, first-stage code 0, second-stage field 1). Neither enable pulses, and the running flag is low.
- R3: The first-stage field (bits [4:2], code c in 0..4) makes the high-speed enable pulse once every 2^c parent cycles. Code 0 holds the enable high continuously.
- R4: First-stage codes 5, 6 and 7 divide by 16, the same as code 4. Read-back still returns the written code.
- R5: Second-stage field bits [1:0]: when bit 0 is 1, the card period is four high-speed periods; when bit 0 is 0, it is two. Bit 1 has no effect on the divide.
- R6: The card enable period is the product of the two stages, from 2 to 64 parent cycles. Every card pulse coincides with a high-speed pulse whenever the high-speed output is running.
- R7: Bit 9 set holds the high-speed enable low, and the card enable keeps its rate.
- R8: Bit 8 set holds the card enable low, and the high-speed enable keeps its rate.
- R9: The running flag is high only while both applied stop bits are 0, and it can rise only at the end of a card period.
- R10: A written setting takes effect at the end of the card period that is in progress when it is written, so no card period shorter than both the old and the new period occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to write |
| rdData | output | 16 | Read-back of the stored control word |
| hsClkEn | output | 1 | High-speed clock enable, one parent cycle wide |
| cardClkEn | output | 1 | Card clock enable, one parent cycle wide |
| clkRunning | output | 1 | Both applied stop bits are clear |

## Verification
A corrupted applied setting or period counter appears as a wrong number of enable pulses over any window of 128 parent cycles. Because every legal period divides 128, the error shows within one window of its onset, whatever the phase. A setting applied in mid-period instead of at the period end shows as an early card pulse. A cycle-exact check after a change from ÷64 to ÷2 catches it on the very first pulse. A bad store or a bad read-back mask shows on the cycle right after the write.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Bit positions of the control word fields
  localparam int unsigned HS_STOP_POS   = 9;
  localparam int unsigned CARD_STOP_POS = 8;
  localparam int unsigned SRC_LSB       = 2;
  localparam int unsigned SRC_W         = 3;
  localparam int unsigned POST_LSB      = 0;
  localparam int unsigned POST_W        = 2;

  typedef struct packed {
    logic              stopHs;
    logic              stopCard;
    logic [SRC_W-1:0]  srcCode;
    logic [POST_W-1:0] postSel;
  } divCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic applyCfg;
  } ctrlStrobe_t;

  localparam divCfg_t CFG_RESET = '{stopHs: 1'b1, stopCard: 1'b1,
                                    srcCode: '0, postSel: POST_W'(1)};

endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             periodEnd,
  output logic [REG_W-1:0] rdData,
  output divCfg_t          pendCfg,
  output ctrlStrobe_t      strobe
);

  localparam logic [REG_W-1:0] RD_MASK =
      (REG_W'(1) << HS_STOP_POS) | (REG_W'(1) << CARD_STOP_POS) |
      (((REG_W'(1) << SRC_W) - REG_W'(1)) << SRC_LSB) |
      (((REG_W'(1) << POST_W) - REG_W'(1)) << POST_LSB);

  divCfg_t shadowCfg;
  logic    dirty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= CFG_RESET;
      dirty     <= 1'b0;
    end else begin
      if (wrEn) begin
        shadowCfg.stopHs   <= wrData[HS_STOP_POS];
        shadowCfg.stopCard <= wrData[CARD_STOP_POS];
        shadowCfg.srcCode  <= wrData[SRC_LSB +: SRC_W];
        shadowCfg.postSel  <= wrData[POST_LSB +: POST_W];
        dirty              <= 1'b1;
      end else if (strobe.applyCfg) begin
        dirty <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.applyCfg = periodEnd & dirty;
    pendCfg         = shadowCfg;
  end

  always_comb begin
    rdData                          = '0;
    rdData[HS_STOP_POS]             = shadowCfg.stopHs;
    rdData[CARD_STOP_POS]           = shadowCfg.stopCard;
    rdData[SRC_LSB +: SRC_W]        = shadowCfg.srcCode;
    rdData[POST_LSB +: POST_W]      = shadowCfg.postSel;
  end

  // R1
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & RD_MASK));

  // R10
  apply_needs_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyCfg |-> periodEnd);

endmodule

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sdclk_pkg::*;
#(
  parameter int unsigned SRC_CODE_MAX = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  divCfg_t     pendCfg,
  input  ctrlStrobe_t strobe,
  output logic        periodEnd,
  output logic        hsClkEn,
  output logic        cardClkEn,
  output logic        clkRunning
);

  localparam int unsigned MAX_LOG = SRC_CODE_MAX + 2;
  localparam int unsigned CNT_W   = MAX_LOG;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

  divCfg_t          activeCfg;
  logic [CNT_W-1:0] cnt;
  logic [LOG_W-1:0] hsLog;
  logic [LOG_W-1:0] cardLog;
  logic [CNT_W-1:0] hsMask;
  logic [CNT_W-1:0] lastCnt;

  // Reserved first-stage codes saturate at the largest legal code
  always_comb begin
    if (activeCfg.srcCode > SRC_W'(SRC_CODE_MAX))
      hsLog = LOG_W'(SRC_CODE_MAX);
    else
      hsLog = LOG_W'(activeCfg.srcCode);
    cardLog = hsLog + (activeCfg.postSel[0] ? LOG_W'(2) : LOG_W'(1));
    hsMask  = ~({CNT_W{1'b1}} << hsLog);
    lastCnt = ~({CNT_W{1'b1}} << cardLog);
  end

  assign periodEnd = (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeCfg <= CFG_RESET;
    end else if (periodEnd) begin
      cnt <= '0;
      if (strobe.applyCfg) activeCfg <= pendCfg;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    hsClkEn    = !activeCfg.stopHs && ((cnt & hsMask) == hsMask);
    cardClkEn  = !activeCfg.stopCard && periodEnd;
    clkRunning = !activeCfg.stopHs && !activeCfg.stopCard;
  end

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(activeCfg));

  // R6
  card_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardClkEn && !activeCfg.stopHs) |-> hsClkEn);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt);

  // R9
  run_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRunning) |-> $past(periodEnd));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int unsigned REG_W        = 16,
  parameter int unsigned SRC_CODE_MAX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             hsClkEn,
  output logic             cardClkEn,
  output logic             clkRunning
);

  divCfg_t     pendCfg;
  ctrlStrobe_t strobe;
  logic        periodEnd;

  sdclk_ctrl #(.REG_W(REG_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .periodEnd (periodEnd),
    .rdData    (rdData),
    .pendCfg   (pendCfg),
    .strobe    (strobe)
  );

  sdclk_datapath #(.SRC_CODE_MAX(SRC_CODE_MAX)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pendCfg    (pendCfg),
    .strobe     (strobe),
    .periodEnd  (periodEnd),
    .hsClkEn    (hsClkEn),
    .cardClkEn  (cardClkEn),
    .clkRunning (clkRunning)
  );

endmodule

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        hsClkEn, cardClkEn, clkRunning;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    hsCnt;
    int    cardCnt;
    bit    run;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  event goEv, doneEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .hsClkEn(hsClkEn), .cardClkEn(cardClkEn),
    .clkRunning(clkRunning)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected item and counts pulses over one window
  initial begin
    forever begin
      expItem_t it;
      int hsN, cardN;
      bit runOk;
      @(goEv);
      it = expQ.pop_front();
      hsN = 0; cardN = 0; runOk = 1'b1;
      for (int i = 0; i < WIN; i++) begin
        @(negedge clk);
        if (hsClkEn) hsN++;
        if (cardClkEn) cardN++;
        if (clkRunning != it.run) runOk = 1'b0;
      end
      chk(hsN == it.hsCnt, {it.tag, " hs pulses"}, hsN, it.hsCnt);
      chk(cardN == it.cardCnt, {it.tag, " card pulses"}, cardN, it.cardCnt);
      chk(runOk, {it.tag, " running flag"}, int'(clkRunning), int'(it.run));
      ->doneEv;
    end
  end

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: pushes the expected window result derived from the control word
  task automatic runSetting(input logic [15:0] v, input string tag);
    expItem_t it;
    int hsLog, cardLog, code;
    writeReg(v);
    chk(rdData == (v & 16'h031F), {tag, " R1 read-back"}, rdData, v & 16'h031F);
    repeat (140) @(negedge clk);
    code    = int'(v[4:2]);
    hsLog   = (code > 4) ? 4 : code;
    cardLog = hsLog + (v[0] ? 2 : 1);
    it.hsCnt   = v[9] ? 0 : (WIN >> hsLog);
    it.cardCnt = v[8] ? 0 : (WIN >> cardLog);
    it.run     = !v[9] && !v[8];
    it.tag     = tag;
    expQ.push_back(it);
    ->goEv;
    @(doneEv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    expItem_t it;
    int tickCnt;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(rdData == 16'h0301, "R2 reset read-back", rdData, 16'h0301);
    it.hsCnt = 0; it.cardCnt = 0; it.run = 1'b0; it.tag = "R2 reset";
    expQ.push_back(it);
    ->goEv;
    @(doneEv);

    runSetting(16'h0001, "R3 R6 code0 div4");
    runSetting(16'h0000, "R5 code0 div2");
    runSetting(16'h0009, "R3 code2 div4");
    runSetting(16'h0010, "R3 R6 code4 div2");
    runSetting(16'h0011, "R6 code4 div4 max");
    runSetting(16'h001D, "R4 reserved code7");
    runSetting(16'h0015, "R4 reserved code5");
    runSetting(16'h0002, "R5 bit1 ignored");
    runSetting(16'h0205, "R7 hs stopped");
    runSetting(16'h0105, "R8 card stopped");
    runSetting(16'hFFFF, "R1 R9 all ones");

    // R10: change from /64 to /2 takes effect only at the period end
    runSetting(16'h0011, "R10 setup");
    do @(negedge clk); while (!cardClkEn);
    wrEn = 1'b1; wrData = 16'h0000;
    @(negedge clk);
    wrEn = 1'b0;
    tickCnt = 0;
    if (cardClkEn) tickCnt++;
    for (int i = 0; i < 62; i++) begin
      @(negedge clk);
      if (cardClkEn) tickCnt++;
    end
    chk(tickCnt == 0, "R10 no early card pulse", tickCnt, 0);
    @(negedge clk);
    chk(cardClkEn == 1'b1, "R10 old period completes", int'(cardClkEn), 1);
    @(negedge clk);
    chk(cardClkEn == 1'b0, "R10 new period first cycle", int'(cardClkEn), 0);
    @(negedge clk);
    chk(cardClkEn == 1'b1, "R10 new period pulse", int'(cardClkEn), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule